// File: doc/BRIEF.md
# Latched Parity Bus Transceiver

This block joins two 9-bit buses, A and B. Each bus word holds 8 data bits in bits 7..0 and a parity bit in bit 8. Each side has its own transparent-latch register. It loads on every rising clock edge while its enable is high and keeps its value while the enable is low. The contents of one latch can be driven onto the opposite bus. The parity bit on that bus is either freshly generated from the latched data or the latched incoming parity bit passed through unchanged. The choice is made at run time.

Parity sense is selectable between odd and even. Two active-low error flags watch the two latches at all times, including when neither bus is driven. That lets a host use them as interrupts for corrupted words in either direction. Each physical tri-state pin is split into an input port, an output port and a drive-enable output.

While a bus is driven by the block, its own latch takes the word the block drives, just as it would from the shared wire, and not the separate input port. A request to drive both buses at once is refused: neither bus is driven, and a sticky violation flag is raised.

Top module: `parity_xcvr`

## Requirements
- R1: A latch loads its 9-bit input at a rising clock edge when its enable is high and holds otherwise. While the block drives that bus, the latch loads the driven word instead of the input port.
- R2: With par_sel = 0 (generate), output bit 8 is 1 exactly when the count of ones in the latched data bits 7..0 is even and odd_sel = 1, or odd and odd_sel = 0.
- R3: With par_sel = 1 (feed-through), output bit 8 equals the latched incoming bit 8. Bits 7..0 always equal the latched data.
- R4: b_en_n = 0 with a_en_n = 1 drives the A latch word on b_out with b_drv = 1, and the reverse drives the B latch word on a_out with a_drv = 1. Both enables high drives nothing: both drive flags are 0 and both outputs are 0.
- R5: err_a_n and err_b_n go low when their loaded latch's 9-bit ones count is even with odd_sel = 1, or odd with odd_sel = 0. This holds whatever the enable inputs are.
- R6: While a bus is driven in generate mode, that bus's error flag stays high.
- R7: a_en_n = 0 together with b_en_n = 0 drives neither bus, and sets conflict from the next cycle until reset.
- R8: A synchronous reset (rst high) clears both latches and conflict. It also holds both error flags high until the latch concerned first loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 9 | A bus value seen at the pins |
| a_out | output | 9 | Word driven onto A |
| a_drv | output | 1 | Drive enable for the A pins |
| b_in | input | 9 | B bus value seen at the pins |
| b_out | output | 9 | Word driven onto B |
| b_drv | output | 1 | Drive enable for the B pins |
| a_le | input | 1 | A latch enable, high = transparent |
| b_le | input | 1 | B latch enable, high = transparent |
| a_en_n | input | 1 | Request to drive A from the B latch, active low |
| b_en_n | input | 1 | Request to drive B from the A latch, active low |
| par_sel | input | 1 | 0 = generate parity, 1 = feed-through |
| odd_sel | input | 1 | 0 = even parity, 1 = odd parity |
| err_a_n | output | 1 | A latch parity error, active low |
| err_b_n | output | 1 | B latch parity error, active low |
| conflict | output | 1 | Sticky dual-drive violation |

## Verification
A corrupted latch bit shows at once on the driven bus data. It also flips the parity bit produced in generate mode and the error flag of that side, all in the cycle after the load edge. The sweeps cover every data and parity pattern in both directions and both senses, so no single wrong bit goes unseen. A latch that fails to hold shows as a changed output word one cycle after the input moves with its enable low. A latch that wrongly takes the pin input while its bus is driven shows as the wrong error flag two edges into a feed-through transfer.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  typedef enum logic {PAR_GEN = 1'b0, PAR_PASS = 1'b1} par_mode_e;
  typedef enum logic {SENSE_EVEN = 1'b0, SENSE_ODD = 1'b1} par_sense_e;
endpackage

// File: rtl/pxc_latch.sv
module pxc_latch #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          le,
  input  logic          self_drive,
  input  logic [WW-1:0] d_pin,
  input  logic [WW-1:0] d_own,
  output logic [WW-1:0] q,
  output logic          loaded
);
  logic [WW-1:0] d_sel;

  // a driven bus reads back its own driver, not the foreign pin value
  assign d_sel = self_drive ? d_own : d_pin;

  always_ff @(posedge clk) begin
    if (rst) begin
      q      <= '0;
      loaded <= 1'b0;
    end else if (le) begin
      q      <= d_sel;
      loaded <= 1'b1;
    end
  end
endmodule

// File: rtl/pxc_gen.sv
module pxc_gen #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input  logic          [WW-1:0] word_in,
  input  pxc_pkg::par_mode_e     mode,
  input  pxc_pkg::par_sense_e    sense,
  output logic          [WW-1:0] word_out
);
  logic fresh;

  // odd sense: set when data has an even count of ones
  assign fresh    = (^word_in[DW-1:0]) ^ (sense == pxc_pkg::SENSE_ODD);
  assign word_out = {(mode == pxc_pkg::PAR_PASS) ? word_in[DW] : fresh,
                     word_in[DW-1:0]};
endmodule

// File: rtl/pxc_chk.sv
module pxc_chk #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input  logic          [WW-1:0] word,
  input  pxc_pkg::par_sense_e    sense,
  input  logic                   loaded,
  input  logic                   blocked,
  output logic                   err_n
);
  logic odd_count;

  assign odd_count = ^word;
  assign err_n = !(loaded && !blocked &&
                   (odd_count != (sense == pxc_pkg::SENSE_ODD)));
endmodule

// File: rtl/parity_xcvr.sv
module parity_xcvr #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [WW-1:0] a_in,
  output logic [WW-1:0] a_out,
  output logic          a_drv,
  input  logic [WW-1:0] b_in,
  output logic [WW-1:0] b_out,
  output logic          b_drv,
  input  logic          a_le,
  input  logic          b_le,
  input  logic          a_en_n,
  input  logic          b_en_n,
  input  logic          par_sel,
  input  logic          odd_sel,
  output logic          err_a_n,
  output logic          err_b_n,
  output logic          conflict
);
  import pxc_pkg::*;

  par_mode_e     mode;
  par_sense_e    sense;
  logic          dual_req;
  logic [WW-1:0] a_q, b_q, to_b, to_a;
  logic          a_loaded, b_loaded;
  logic          conflict_q;

  assign mode     = par_mode_e'(par_sel);
  assign sense    = par_sense_e'(odd_sel);
  assign dual_req = !a_en_n && !b_en_n;
  assign b_drv    = !b_en_n && a_en_n;
  assign a_drv    = !a_en_n && b_en_n;

  pxc_latch #(.DW(DW)) lat_a_i (
    .clk(clk), .rst(rst), .le(a_le), .self_drive(a_drv),
    .d_pin(a_in), .d_own(to_a), .q(a_q), .loaded(a_loaded));

  pxc_latch #(.DW(DW)) lat_b_i (
    .clk(clk), .rst(rst), .le(b_le), .self_drive(b_drv),
    .d_pin(b_in), .d_own(to_b), .q(b_q), .loaded(b_loaded));

  pxc_gen #(.DW(DW)) gen_ab_i (.word_in(a_q), .mode(mode), .sense(sense), .word_out(to_b));
  pxc_gen #(.DW(DW)) gen_ba_i (.word_in(b_q), .mode(mode), .sense(sense), .word_out(to_a));

  assign b_out = b_drv ? to_b : '0;
  assign a_out = a_drv ? to_a : '0;

  pxc_chk #(.DW(DW)) chk_a_i (
    .word(a_q), .sense(sense), .loaded(a_loaded),
    .blocked(a_drv && mode == PAR_GEN), .err_n(err_a_n));

  pxc_chk #(.DW(DW)) chk_b_i (
    .word(b_q), .sense(sense), .loaded(b_loaded),
    .blocked(b_drv && mode == PAR_GEN), .err_n(err_b_n));

  always_ff @(posedge clk) begin
    if (rst)           conflict_q <= 1'b0;
    else if (dual_req) conflict_q <= 1'b1;
  end
  assign conflict = conflict_q;
endmodule

// File: rtl/pxc_props.sv
module pxc_props #(
  parameter int DW = 8,
  localparam int WW = DW + 1
) (
  input logic          clk,
  input logic          rst,
  input logic [WW-1:0] a_out,
  input logic          a_drv,
  input logic [WW-1:0] b_out,
  input logic          b_drv,
  input logic          a_le,
  input logic          b_le,
  input logic          a_en_n,
  input logic          b_en_n,
  input logic          par_sel,
  input logic          odd_sel,
  input logic          err_a_n,
  input logic          err_b_n,
  input logic          conflict
);
  a_r4_single_driver: assert property (@(posedge clk) disable iff (rst)
    !(a_drv && b_drv));

  a_r4_released: assert property (@(posedge clk) disable iff (rst)
    (a_en_n && b_en_n) |-> (!a_drv && !b_drv && a_out == '0 && b_out == '0));

  a_r7_conflict_set: assert property (@(posedge clk) disable iff (rst)
    (!a_en_n && !b_en_n) |=> conflict);

  a_r7_conflict_sticky: assert property (@(posedge clk) disable iff (rst)
    conflict |=> conflict);

  a_r1_hold_ab: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(a_le) && b_drv && $past(b_drv) &&
     $stable(par_sel) && $stable(odd_sel)) |-> $stable(b_out));

  a_r1_hold_ba: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(b_le) && a_drv && $past(a_drv) &&
     $stable(par_sel) && $stable(odd_sel)) |-> $stable(a_out));

  a_r6_recv_b_blocked: assert property (@(posedge clk) disable iff (rst)
    (b_drv && !par_sel) |-> err_b_n);

  a_r6_recv_a_blocked: assert property (@(posedge clk) disable iff (rst)
    (a_drv && !par_sel) |-> err_a_n);

  a_r8_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (err_a_n && err_b_n && !conflict));
endmodule

bind parity_xcvr pxc_props #(.DW(DW)) props_i (
  .clk(clk), .rst(rst), .a_out(a_out), .a_drv(a_drv), .b_out(b_out),
  .b_drv(b_drv), .a_le(a_le), .b_le(b_le), .a_en_n(a_en_n), .b_en_n(b_en_n),
  .par_sel(par_sel), .odd_sel(odd_sel), .err_a_n(err_a_n), .err_b_n(err_b_n),
  .conflict(conflict));

// File: tb/parity_xcvr_tb_top.sv
module parity_xcvr_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] a_in = '0, b_in = '0;
  logic [8:0] a_out, b_out;
  logic       a_drv, b_drv, err_a_n, err_b_n, conflict;
  logic       a_le = 0, b_le = 0, a_en_n = 1, b_en_n = 1, par_sel = 0, odd_sel = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  parity_xcvr dut_i (
    .clk(clk), .rst(rst), .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv), .a_le(a_le), .b_le(b_le),
    .a_en_n(a_en_n), .b_en_n(b_en_n), .par_sel(par_sel), .odd_sel(odd_sel),
    .err_a_n(err_a_n), .err_b_n(err_b_n), .conflict(conflict));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock: inputs set before call, sample just after the edge
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int ones(input logic [8:0] w, input int n);
    int c = 0;
    for (int i = 0; i < n; i++) c += w[i];
    return c;
  endfunction

  function automatic logic [8:0] exp_word(input logic [8:0] w, input bit pass, input bit odd);
    logic p;
    if (pass) p = w[8];
    else      p = ((ones(w, 8) % 2) == 0) ? odd : !odd;
    return {p, w[7:0]};
  endfunction

  function automatic bit exp_err_n(input logic [8:0] w, input bit odd);
    return ((ones(w, 9) % 2) == 1) == odd;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] w;
    @(negedge clk); @(negedge clk);
    rst = 0; odd_sel = 1;
    #1;
    // R8: reset state, flags high even in odd sense with zeroed latches
    chk(err_a_n && err_b_n, "R8 flags after reset", {err_a_n, err_b_n}, 3);
    chk(!conflict && !a_drv && !b_drv, "R8 conflict/drives", {conflict, a_drv, b_drv}, 0);
    chk(a_out == 0 && b_out == 0, "R8 outputs", {a_out, b_out}, 0);

    // A to B sweep: all data and parity patterns, both modes and senses
    for (int pm = 0; pm < 2; pm++)
      for (int od = 0; od < 2; od++)
        for (int v = 0; v < 512; v++) begin
          @(negedge clk);
          a_le = 1; b_le = 0; a_en_n = 1; b_en_n = 0;
          par_sel = pm[0]; odd_sel = od[0]; w = v[8:0]; a_in = w;
          step();
          chk(b_out == exp_word(w, pm[0], od[0]), pm[0] ? "R3 A->B word" : "R2 A->B word",
              b_out, exp_word(w, pm[0], od[0]));
          chk(b_drv && !a_drv, "R4 A->B drive", {a_drv, b_drv}, 1);
          chk(err_a_n == exp_err_n(w, od[0]), "R5 err_a_n", err_a_n, exp_err_n(w, od[0]));
        end

    // B to A sweep
    for (int pm = 0; pm < 2; pm++)
      for (int od = 0; od < 2; od++)
        for (int v = 0; v < 512; v++) begin
          @(negedge clk);
          a_le = 0; b_le = 1; a_en_n = 0; b_en_n = 1;
          par_sel = pm[0]; odd_sel = od[0]; w = v[8:0]; b_in = w;
          step();
          chk(a_out == exp_word(w, pm[0], od[0]), pm[0] ? "R3 B->A word" : "R2 B->A word",
              a_out, exp_word(w, pm[0], od[0]));
          chk(a_drv && !b_drv, "R4 B->A drive", {a_drv, b_drv}, 2);
          chk(err_b_n == exp_err_n(w, od[0]), "R5 err_b_n", err_b_n, exp_err_n(w, od[0]));
        end

    // R1: hold while enable low
    @(negedge clk);
    a_le = 1; b_le = 0; a_en_n = 1; b_en_n = 0; par_sel = 1; odd_sel = 0; a_in = 9'h0A5;
    step();
    @(negedge clk); a_le = 0; a_in = 9'h15A;
    step();
    chk(b_out == 9'h0A5, "R1 hold A latch", b_out, 9'h0A5);

    // R5: checking continues with both buses released
    @(negedge clk); a_en_n = 1; b_en_n = 1; a_le = 1; odd_sel = 0; a_in = 9'h001;
    step();
    chk(!err_a_n, "R5 err with buses released", err_a_n, 0);
    chk(!a_drv && !b_drv && a_out == 0 && b_out == 0, "R4 released", {a_drv, b_drv}, 0);

    // R6: generate mode, receive latch transparent, source word bad
    @(negedge clk); b_en_n = 0; a_le = 1; b_le = 1; par_sel = 0; a_in = 9'h001; b_in = 9'h000;
    step(); step();
    chk(err_b_n, "R6 receive flag held high", err_b_n, 1);
    chk(!err_a_n, "R5 source flag low", err_a_n, 0);

    // R1: feed-through, B latch takes the driven word not b_in (b_in is valid)
    @(negedge clk); par_sel = 1;
    step(); step();
    chk(!err_b_n, "R1 B latch loads driven word", err_b_n, 0);

    // R7: dual request
    @(negedge clk); a_le = 0; b_le = 0; a_en_n = 0; b_en_n = 0;
    #1;
    chk(!a_drv && !b_drv, "R7 no drive on dual request", {a_drv, b_drv}, 0);
    step();
    chk(conflict, "R7 conflict set", conflict, 1);
    @(negedge clk); a_en_n = 1; b_en_n = 1;
    step(); step();
    chk(conflict, "R7 conflict sticky", conflict, 1);

    // R8: reset again clears conflict and primes
    @(negedge clk); rst = 1; odd_sel = 1;
    step();
    @(negedge clk); rst = 0;
    #1;
    chk(!conflict && err_a_n && err_b_n, "R8 second reset", {conflict, err_a_n, err_b_n}, 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule